// File: doc/BRIEF.md
# Indirect Embedded-RAM Access Port

This block gives a host processor a byte-wide register window into several internal word-wide RAMs: transmit filter, two echo cancellers, decision-feedback equalizer, equalizer and microcode store. The host never addresses a RAM word directly. Every RAM shares one 32-bit data register. Each RAM also has two select registers of its own, one for reads and one for writes. Writing a location address into a select register queues an access. The access is carried out later, on a symbol-clock enable.

To write a word, the host first fills the data register and then writes the target address to the RAM's write-select register. The data register keeps its value afterwards, so the host can store one word at several locations by writing only new addresses. To read a word, the host writes the address to the RAM's read-select register and waits for the read busy flag to drop. The word is then in the data register.

RAM operations run only on cycles where `sym_en` is high. After any access, the next symbol enable is left empty. That empty slot also carries the return of read data. Requests that arrive while another access is outstanding wait in a per-request pending flag until a free slot comes.

Top module: `ram_window`

## Requirements
- R1: After reset the data register reads zero, every select register reads back zero, and both busy registers (offset 0x40 for reads, 0x41 for writes) read zero.
- R2: The data register sits at offsets 0x7C to 0x7F. Offset 0x7C+k holds bits 8k+7:8k. Each byte can be written and read back by the host on its own.
- R3: Writing an address to the write-select register of RAM i (offset 2i+1) stores the data register's value at that location of RAM i. The data register is left unchanged, so one loaded value can be committed to several locations by address writes alone.
- R4: Writing an address to the read-select register of RAM i (offset 2i) sets bit i of the read busy register (0x40). When that bit clears, the data register holds the addressed word of RAM i. Bit i of 0x41 shows a write to RAM i that has not yet been performed.
- R5: A RAM access (a read strobe `ram_re` or a write strobe `ram_we`) happens only in a cycle with `sym_en` high, to at most one RAM at a time. No access happens on the symbol enable that directly follows one with an access.
- R6: Pending requests are served in fixed priority by request index: read of RAM i = 2i, write of RAM i = 2i+1, lowest index first. A read's word is loaded into the data register on the symbol enable after its access.
- R7: A select write to a request that is pending, or that is being served in the same cycle, replaces the latched address and leaves the request pending. The request is served again later with the new address.
- R8: If a read's data return and a host write to a data-register byte fall on the same clock edge, the returned word wins for all four bytes.
- R9: Only the low log2(DEPTH) bits of a select write are kept (4 bits at DEPTH=16). A select register reads back those bits, zero-extended.
- R10: A host write to an unmapped offset changes no register, and a read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_en | input | 1 | Symbol-clock enable; RAM accesses happen only when high |
| host_addr | input | 7 | Host register offset |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for host_addr (combinational) |
| ram_re | output | N_RAM | One-hot read strobe, one bit per RAM |
| ram_we | output | N_RAM | One-hot write strobe, one bit per RAM |
| ram_addr | output | log2(DEPTH) | Location of the access being performed |
| ram_wdata | output | 32 | Word written on a write strobe |

## Verification
Two pairs of functions can meet in one cycle. The first is a host select write and the service of that same request. The bench drives `sym_en` by hand and rewrites a pending write-select in the very cycle it is granted. The access must go out with the old address, the request must stay pending, and a later slot must store the same word at the new address. The second is a host data-byte write landing on a read's return edge, where the read word must win. Priority order is judged the same way. Three requests are posted with no symbol enable, then the strobe vector is compared slot by slot against the index order. A sweep over every location of every RAM, with values computed from RAM index and address, covers the plain paths.

// File: rtl/ram_window.sv
module ram_window #(
  parameter int N_RAM = 6,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NREQ = 2 * N_RAM,
  localparam int IW   = $clog2(NREQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_en,
  input  logic [6:0]       host_addr,
  input  logic             host_we,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic [N_RAM-1:0] ram_re,
  output logic [N_RAM-1:0] ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [31:0]      ram_wdata
);

  logic [31:0]     data_q;
  logic [AW-1:0]   sel_addr [NREQ];
  logic [NREQ-1:0] pend;
  logic            gap, ret;
  logic [IW-2:0]   ret_ram;
  logic [31:0]     ret_word;
  logic [31:0]     rd_word [N_RAM];
  logic [IW-1:0]   gidx;
  logic [N_RAM-1:0] rd_busy, wr_busy;

  wire host_sel  = host_we && (host_addr < 7'(NREQ));
  wire host_data = host_we && (host_addr[6:2] == 5'h1F);
  wire serve     = sym_en && !gap && (|pend);
  wire [IW-2:0] gram = gidx[IW-1:1];

  always_comb begin
    gidx = '0;
    for (int g = NREQ - 1; g >= 0; g--)
      if (pend[g]) gidx = IW'(g);
  end

  always_comb begin
    for (int i = 0; i < N_RAM; i++) begin
      ram_re[i]  = serve && !gidx[0] && (gram == (IW-1)'(i));
      ram_we[i]  = serve &&  gidx[0] && (gram == (IW-1)'(i));
      rd_busy[i] = pend[2*i] || (ret && ret_ram == (IW-1)'(i));
      wr_busy[i] = pend[2*i+1];
    end
  end

  assign ram_addr  = sel_addr[gidx];
  assign ram_wdata = data_q;

  for (genvar i = 0; i < N_RAM; i++) begin : g_ram
    logic [31:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (ram_we[i]) mem[ram_addr] <= data_q;
    assign rd_word[i] = mem[ram_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      pend     <= '0;
      gap      <= 1'b0;
      ret      <= 1'b0;
      ret_ram  <= '0;
      ret_word <= '0;
      for (int r = 0; r < NREQ; r++) sel_addr[r] <= '0;
    end else begin
      if (sym_en) gap <= serve;

      if (serve && !gidx[0]) begin
        ret      <= 1'b1;
        ret_ram  <= gram;
        ret_word <= rd_word[gram];
      end else if (sym_en) begin
        ret <= 1'b0;
      end

      for (int k = 0; k < 4; k++)
        if (host_data && host_addr[1:0] == 2'(k)) data_q[8*k +: 8] <= host_wdata;
      if (sym_en && ret) data_q <= ret_word;

      if (serve) pend[gidx] <= 1'b0;
      if (host_sel) begin
        pend[host_addr[IW-1:0]]     <= 1'b1;
        sel_addr[host_addr[IW-1:0]] <= host_wdata[AW-1:0];
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr < 7'(NREQ))          host_rdata = 8'(sel_addr[host_addr[IW-1:0]]);
    else if (host_addr == 7'h40)       host_rdata = 8'(rd_busy);
    else if (host_addr == 7'h41)       host_rdata = 8'(wr_busy);
    else if (host_addr[6:2] == 5'h1F)  host_rdata = data_q[8*host_addr[1:0] +: 8];
  end

endmodule

module ram_window_chk #(
  parameter int N_RAM = 6,
  parameter int DEPTH = 16,
  localparam int NREQ = 2 * N_RAM,
  localparam int IW   = $clog2(NREQ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sym_en,
  input logic [6:0]       host_addr,
  input logic             host_we,
  input logic [N_RAM-1:0] ram_re,
  input logic [N_RAM-1:0] ram_we,
  input logic [NREQ-1:0]  pend
);

  logic last_acc;
  wire  acc = |{ram_re, ram_we};

  always_ff @(posedge clk)
    if (!rst_n) last_acc <= 1'b0;
    else if (sym_en) last_acc <= acc;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_re, ram_we}));  // R5
  AST_ON_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> sym_en);  // R5
  AST_EVERY_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && last_acc) |-> !acc);  // R5
  AST_ACCESS_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (|pend));  // R6
  AST_SELECT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr < 7'(NREQ)) |=> pend[$past(host_addr[IW-1:0])]);  // R7

endmodule

bind ram_window ram_window_chk #(.N_RAM(N_RAM), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .host_addr(host_addr),
  .host_we(host_we), .ram_re(ram_re), .ram_we(ram_we), .pend(pend)
);

// File: tb/ram_window_tb.sv
module ram_window_tb;
  localparam int N_RAM = 6;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] host_addr = '0;
  logic host_we = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [N_RAM-1:0] ram_re, ram_we;
  logic [3:0] ram_addr;
  logic [31:0] ram_wdata;
  logic auto_sym = 1'b1, auto_pulse = 1'b0, man_sym = 1'b0;
  logic [1:0] cnt = '0;
  logic sym_en;
  int errors = 0, checks = 0, viol = 0;
  logic prev_acc = 1'b0;
  bit done = 0;

  assign sym_en = auto_sym ? auto_pulse : man_sym;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cnt <= cnt + 2'd1;
    auto_pulse <= (cnt == 2'd3);
  end

  ram_window #(.N_RAM(N_RAM), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .host_addr(host_addr),
    .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  always @(negedge clk) if (rst_n) begin
    if ((|{ram_re, ram_we}) && !sym_en) viol++;
    if ($countones({ram_re, ram_we}) > 1) viol++;
    if (sym_en) begin
      if (prev_acc && (|{ram_re, ram_we})) viol++;
      prev_acc = |{ram_re, ram_we};
    end
  end

  function automatic logic [31:0] pat(int i, int a);
    return {8'(i) ^ 8'h5A, 8'(a), ~8'(a), 8'(i * 16 + a)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic set_data(logic [31:0] w);
    for (int k = 0; k < 4; k++) hw(7'h7C + 7'(k), w[8*k +: 8]);
  endtask

  task automatic get_data(output logic [31:0] w);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      hr(7'h7C + 7'(k), b);
      w[8*k +: 8] = b;
    end
  endtask

  task automatic wait_idle();
    logic [7:0] r, w;
    for (int n = 0; n < 400; n++) begin
      hr(7'h40, r);
      hr(7'h41, w);
      if (r == 0 && w == 0) return;
    end
    chk("R4 idle timeout", 32'(r) | 32'(w), 0);
  endtask

  task automatic pulse(bit with_host, logic [6:0] a, logic [7:0] d,
                       output logic [11:0] strobes, output logic [3:0] adr);
    @(negedge clk);
    man_sym = 1'b1;
    if (with_host) begin host_addr = a; host_wdata = d; host_we = 1'b1; end
    #1 strobes = {ram_we, ram_re}; adr = ram_addr;
    @(negedge clk);
    man_sym = 1'b0; host_we = 1'b0;
  endtask

  task automatic ram_read(int i, int a, output logic [31:0] w);
    hw(7'(2 * i), 8'(a));
    wait_idle();
    get_data(w);
  endtask

  initial begin
    logic [31:0] w;
    logic [7:0] b;
    logic [11:0] s;
    logic [3:0] ad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    get_data(w); chk("R1 data reset", w, 0);
    hr(7'h40, b); chk("R1 read busy reset", 32'(b), 0);
    hr(7'h41, b); chk("R1 write busy reset", 32'(b), 0);
    for (int r = 0; r < 2 * N_RAM; r++) begin
      hr(7'(r), b); chk("R1 select reset", 32'(b), 0);
    end

    for (int k = 0; k < 4; k++) hw(7'h7C + 7'(k), 8'h11 * 8'(k + 1));
    for (int k = 0; k < 4; k++) begin
      hr(7'h7C + 7'(k), b); chk("R2 byte lane", 32'(b), 32'(8'h11 * 8'(k + 1)));
    end

    for (int i = 0; i < N_RAM; i++)
      for (int a = 0; a < DEPTH; a++) begin
        set_data(pat(i, a));
        hw(7'(2 * i + 1), 8'(a));
        wait_idle();
        get_data(w); chk("R3 data kept after write", w, pat(i, a));
      end

    hw(7'h00, 8'h07);
    hr(7'h40, b); chk("R4 read busy set", 32'(b & 8'h01), 1);
    wait_idle();
    for (int i = 0; i < N_RAM; i++)
      for (int a = 0; a < DEPTH; a++) begin
        ram_read(i, a, w); chk("R4 sweep readback", w, pat(i, a));
      end

    set_data(32'h0BADF00D);
    for (int a = 1; a <= 3; a++) begin hw(7'd11, 8'(a)); wait_idle(); end
    get_data(w); chk("R3 data reuse kept", w, 32'h0BADF00D);
    for (int a = 1; a <= 3; a++) begin
      ram_read(5, a, w); chk("R3 reuse stored", w, 32'h0BADF00D);
    end

    set_data(32'hDEADBEEF);
    hw(7'd9, 8'hF3);
    hr(7'd9, b); chk("R9 select truncated", 32'(b), 3);
    wait_idle();
    ram_read(4, 3, w); chk("R9 stored at low bits", w, 32'hDEADBEEF);

    get_data(w);
    hw(7'h50, 8'hFF); hw(7'h42, 8'hFF); hw(7'h20, 8'hFF);
    hr(7'h50, b); chk("R10 unmapped reads zero", 32'(b), 0);
    hr(7'h40, b); chk("R10 busy untouched", 32'(b), 0);
    begin logic [31:0] w2; get_data(w2); chk("R10 data untouched", w2, w); end

    // manual symbol pacing from here
    wait_idle();
    auto_sym = 1'b0;
    pulse(0, 0, 0, s, ad); pulse(0, 0, 0, s, ad);
    set_data(32'hC0DE0001);
    hw(7'd3, 8'd7); hw(7'd0, 8'd2); hw(7'd1, 8'd9);
    pulse(0, 0, 0, s, ad); chk("R6 slot1 read ram0", 32'(s), 32'h001);
    chk("R6 slot1 addr", 32'(ad), 2);
    pulse(0, 0, 0, s, ad); chk("R5 slot2 empty", 32'(s), 0);
    get_data(w); chk("R6 read returned", w, pat(0, 2));
    pulse(0, 0, 0, s, ad); chk("R6 slot3 write ram0", 32'(s), 32'h040);
    chk("R6 slot3 addr", 32'(ad), 9);
    pulse(0, 0, 0, s, ad); chk("R5 slot4 empty", 32'(s), 0);
    pulse(0, 0, 0, s, ad); chk("R6 slot5 write ram1", 32'(s), 32'h080);
    chk("R6 slot5 addr", 32'(ad), 7);
    pulse(0, 0, 0, s, ad); chk("R5 slot6 empty", 32'(s), 0);

    set_data(32'h12345678);
    hw(7'd5, 8'd4);
    pulse(1, 7'd5, 8'd6, s, ad); chk("R7 served old address", 32'(s), 32'h100);
    chk("R7 old address", 32'(ad), 4);
    hr(7'd5, b); chk("R7 new address latched", 32'(b), 6);
    hr(7'h41, b); chk("R7 still pending", 32'(b), 32'h04);
    pulse(0, 0, 0, s, ad); chk("R5 gap after R7", 32'(s), 0);
    pulse(0, 0, 0, s, ad); chk("R7 served new address", 32'(s), 32'h100);
    chk("R7 new address used", 32'(ad), 6);
    pulse(0, 0, 0, s, ad);

    hw(7'd0, 8'd5);
    pulse(0, 0, 0, s, ad); chk("R8 read issued", 32'(s), 32'h001);
    pulse(1, 7'h7C, 8'h77, s, ad);
    get_data(w); chk("R8 return wins", w, pat(0, 5));

    auto_sym = 1'b1;
    ram_read(2, 4, w); chk("R7 first word", w, 32'h12345678);
    ram_read(2, 6, w); chk("R7 second word", w, 32'h12345678);
    ram_read(0, 9, w); chk("R6 write ram0 data", w, pat(0, 2));
    ram_read(1, 7, w); chk("R6 write ram1 data", w, pat(0, 2));

    chk("R5 pacing monitor", viol, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule